// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block collects level requests from up to 32 interrupt sources. It latches each request into a per-source cause bit. A per-source enable register selects which latched requests count as pending. The pending sources are merged into one registered interrupt line that goes to a parent controller.

Software works with the block over a simple word bus with no wait states. It enables and disables lines through the enable register, and it acknowledges a request by writing a one to that request's cause bit. A read-only status word gives the index of the lowest-numbered pending source, so the handler does not have to scan the bits itself. For a full shutdown, software writes zero to the enable register and then all ones to the cause register.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, the cause and enable registers are zero, `irq_o` is low and the status word reads zero.
- R2: A source that is high in a cycle sets its cause bit at that clock edge. The bit stays set after the source falls, whatever the enable bit holds.
- R3: A write to byte offset 0x00 clears every cause bit whose write-data bit is one. Cause bits whose write-data bit is zero keep their value.
- R4: If a source is high in the same cycle as an acknowledge of its cause bit, the bit stays set.
- R5: A write to byte offset 0x04 replaces the enable register with the write data. A read of offset 0x04 returns it, and a read of 0x00 returns the cause register.
- R6: The pending set is cause AND enable. `irq_o` is registered: it is high in the cycle after the pending set is nonzero, and low in the cycle after it is zero.
- R7: A read of offset 0x08 returns bit 31 = 1 and bits 4:0 = the lowest index in the pending set, with all other bits zero, whenever the pending set is nonzero.
- R8: When the pending set is zero, offset 0x08 reads as zero, even if cause bits of disabled sources are set.
- R9: Reads of any offset other than 0x00, 0x04 and 0x08 return zero. Writes to such offsets, and writes to 0x08, change no register.
- R10: Writing zero to 0x04 and then all ones to 0x00, with all sources low, leaves both registers zero, the status word zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Level request per source |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read, zero otherwise |
| irq_o | output | 1 | Registered cascade interrupt to the parent |

## Verification
The bench builds the block with its default values: 32 sources and an 8-bit byte offset. With 32 sources the top source, number 31, is in reach, so the status encoder is tested at its widest index, at the same bit position as the valid flag. The 8-bit offset leaves room to test unmapped addresses such as 0x0C and 0xFC. Sparse random sources, mixed with random enable, acknowledge and read traffic, produce many different pending patterns, and several sources are often pending together.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [7:0] OFS_CAUSE = 8'h00;
  localparam logic [7:0] OFS_ENA   = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_CAUSE = 2'd1,
    RSEL_ENA   = 2'd2,
    RSEL_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               ack_en_i,
  input  logic [NUM_SRC-1:0] ack_bits_i,
  input  logic               ena_we_i,
  input  logic [NUM_SRC-1:0] ena_wdata_i,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] ena_o
);
  logic [NUM_SRC-1:0] cause_q, cause_d;
  logic [NUM_SRC-1:0] ena_q, ena_d;
  logic               cause_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      cause_d[i] = src_i[i] | (cause_q[i] & ~(ack_en_i & ack_bits_i[i]));
    end
  end

  always_comb begin
    cause_en = ack_en_i | (|src_i);
    ena_d    = ena_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ena_q <= '0;
    else if (ena_we_i) ena_q <= ena_d;
  end

  assign cause_o = cause_q;
  assign ena_o   = ena_q;

  // R2 / R4: a high source is latched at the next edge, even during an acknowledge
  p_src_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));
  // R3: without an acknowledge no cause bit falls
  p_no_ack_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en_i |=> (($past(cause_q) & ~cause_q) == '0));
  // R9: the enable register only moves on its own write
  p_ena_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_we_i |=> $stable(ena_q));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
    valid_o = |pend_i;
  end

  // R7: the reported index is pending and nothing below it is
  p_idx_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pend_i[idx_o]);
  p_idx_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((pend_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0));
  // R8: no valid flag unless something is pending
  p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (pend_i == '0));
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               rst_n_s;
  reg_sel_e           rsel;
  logic [NUM_SRC-1:0] cause, ena, pend;
  logic               ack_en, ena_we;
  logic               enc_valid;
  logic [IDX_W-1:0]   enc_idx;
  logic [BUS_W-1:0]   stat_word;
  logic               irq_q, irq_d;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    unique case (bus_addr_i)
      ADDR_W'(OFS_CAUSE): rsel = RSEL_CAUSE;
      ADDR_W'(OFS_ENA):   rsel = RSEL_ENA;
      ADDR_W'(OFS_STAT):  rsel = RSEL_STAT;
      default:            rsel = RSEL_NONE;
    endcase
    ack_en = bus_sel_i & bus_we_i & (rsel == RSEL_CAUSE);
    ena_we = bus_sel_i & bus_we_i & (rsel == RSEL_ENA);
  end

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .src_i(src_i),
    .ack_en_i(ack_en), .ack_bits_i(bus_wdata_i[NUM_SRC-1:0]),
    .ena_we_i(ena_we), .ena_wdata_i(bus_wdata_i[NUM_SRC-1:0]),
    .cause_o(cause), .ena_o(ena)
  );

  assign pend = cause & ena;

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .clk(clk), .rst_n(rst_n_s), .pend_i(pend),
    .valid_o(enc_valid), .idx_o(enc_idx)
  );

  always_comb begin
    stat_word = '0;
    stat_word[BUS_W-1]   = enc_valid;
    stat_word[IDX_W-1:0] = enc_idx;
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (rsel)
        RSEL_CAUSE: bus_rdata_o = BUS_W'(cause);
        RSEL_ENA:   bus_rdata_o = BUS_W'(ena);
        RSEL_STAT:  bus_rdata_o = stat_word;
        default:    bus_rdata_o = '0;
      endcase
    end
    irq_d = |pend;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R6: the cascade line follows the enabled latched set one cycle later
  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    enc_valid |=> irq_o);
  p_irq_drops_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enc_valid |=> !irq_o);
  // R9: an unmapped offset always reads zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsel == RSEL_NONE) |-> (bus_rdata_o == '0));
endmodule

// File: tb/tb_irq_agg_ctrl.sv
`timescale 1ns/1ps
module tb_irq_agg_ctrl;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          sel, we;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  logic [NS-1:0] m_cause, m_ena;
  logic          m_irq;

  always #2 clk = ~clk;

  irq_agg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_stat(logic [NS-1:0] p);
    logic [31:0] r = '0;
    for (int i = NS - 1; i >= 0; i--) if (p[i]) r = 32'h8000_0000 | i;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00:   return m_cause;
      8'h04:   return m_ena;
      8'h08:   return exp_stat(m_cause & m_ena);
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle. Checks irq_o at the start and read data mid-cycle.
  task automatic cyc(string tag, logic [NS-1:0] s, logic v, logic w,
                     logic [7:0] a, logic [31:0] d);
    logic [NS-1:0] nc, ne;
    logic          ni;
    @(negedge clk);
    check("R6 irq", {31'b0, irq}, {31'b0, m_irq});
    src = s; sel = v; we = w; addr = a; wdata = d;
    #1;
    if (v && !w) check(tag, rdata, exp_read(a));
    nc = m_cause; ne = m_ena;
    ni = |(m_cause & m_ena);
    if (v && w && a == 8'h00) nc = nc & ~d;
    if (v && w && a == 8'h04) ne = d;
    nc = nc | s;
    @(posedge clk);
    m_cause = nc; m_ena = ne; m_irq = ni;
  endtask

  task automatic rd(string tag, logic [7:0] a);
    cyc(tag, '0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [NS-1:0] s = '0);
    cyc("wr", s, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; src = '0; sel = 0; we = 0; addr = '0; wdata = '0;
    m_cause = '0; m_ena = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd("R1 cause", 8'h00);
    rd("R1 ena", 8'h04);
    rd("R1 stat", 8'h08);
    check("R1 irq", {31'b0, irq}, 32'b0);

    // R2 latch while disabled; R8 status zero
    cyc("R2", 32'h0000_0008, 1'b0, 1'b0, 8'h00, '0);
    rd("R2 cause held", 8'h00);
    rd("R8 disabled cause", 8'h08);

    // R5 enable write/readback, R6 irq, R7 index
    wr(8'h04, 32'h0000_0008);
    rd("R5 ena", 8'h04);
    rd("R7 stat idx3", 8'h08);

    // R3 zero-write no effect, then clear
    wr(8'h00, 32'h0000_0000);
    rd("R3 zero write", 8'h00);
    wr(8'h00, 32'h0000_0008);
    rd("R3 cleared", 8'h00);
    rd("R8 none pending", 8'h08);

    // R4 set wins over acknowledge
    wr(8'h04, 32'hFFFF_FFFF);
    cyc("R4", 32'h0000_0020, 1'b0, 1'b0, 8'h00, '0);
    wr(8'h00, 32'h0000_0020, 32'h0000_0020);
    rd("R4 still set", 8'h00);
    wr(8'h00, 32'h0000_0020);

    // R7 priority with top source
    cyc("R7", 32'h8000_0080, 1'b0, 1'b0, 8'h00, '0);
    rd("R7 idx7", 8'h08);
    wr(8'h00, 32'h0000_0080);
    rd("R7 idx31", 8'h08);

    // R9 unmapped offsets and status write
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h0000_0000);
    wr(8'h08, 32'h0000_0000);
    rd("R9 read 0C", 8'h0C);
    rd("R9 read FC", 8'hFC);
    rd("R9 ena kept", 8'h04);
    rd("R9 cause kept", 8'h00);

    // R10 quiesce
    wr(8'h04, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R10 cause", 8'h00);
    rd("R10 ena", 8'h04);
    rd("R10 stat", 8'h08);
    check("R10 irq", {31'b0, irq}, 32'b0);

    // random traffic: R2..R9
    for (int n = 0; n < 3000; n++) begin
      logic [NS-1:0] s;
      logic [7:0]    a;
      int            k;
      s = $urandom & $urandom & $urandom & $urandom;
      k = $urandom_range(0, 3);
      a = (k == 3) ? 8'(($urandom_range(0, 63)) << 2) : 8'(k * 4);
      cyc("R7 random read", s, $urandom_range(0, 1), $urandom_range(0, 1), a, $urandom);
    end
    rd("R5 final", 8'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule